// File: doc/BRIEF.md
# Coded Bit Rate Limiter

This block sits between the stage that gathers the coded bits of several symbols and a byte packer that can take in no more than eight bits per clock. In each cycle the upstream side may offer one chunk of up to sixteen coded bits. The chunk's first bit sits at the most significant position, and a length field says how many of the bits are real. The block never passes more than eight bits per cycle to the packer. Bits it cannot forward yet stay in a left-aligned holding register. When the next chunk arrives, the held bits are placed in front of it, so the order of the bit stream never changes.

When the held and the new bits together fit in eight bits, all of them leave in the same cycle and the holding register empties. When they do not fit, the eight oldest bits leave and the rest stay held. The upstream side is stalled while the held count is above eight. In that state a further sixteen-bit chunk could not fit beside the held bits in the 24-bit merge window. While stalled, the block keeps emitting full bytes from the holding register until it drains.

Top module: `bitstream_rate_limiter`

## Requirements
- R1: After reset the holding register is empty: `out_valid` is 0 and `in_ready` is 1 while no input is offered.
- R2: When held bits plus accepted bits total 8 or fewer, `out_len` equals that total in the same cycle, and the holding register is empty on the next cycle.
- R3: When the total exceeds 8, `out_len` is 8 and the bits beyond the first eight are kept for later cycles.
- R4: Held bits are emitted before newly accepted bits. Output bits leave MSB first (`out_data[7]` first), so the concatenated output stream equals the concatenated input stream.
- R5: `in_ready` is 1 exactly when 8 or fewer bits are held. While more are held, every cycle emits a full byte.
- R6: An accepted chunk with `in_len` = 0 and an empty holding register gives `out_valid` = 1 and `out_len` = 0.
- R7: With no input accepted and a non-empty holding register, the block still emits min(8, held) bits that cycle.
- R8: Bits of `in_data` below the top `in_len` positions are ignored and never appear on the output.
- R9: The positions of `out_data` below the top `out_len` bits are driven to 0.
- R10: A chunk offered while `in_ready` is 0 is not consumed and adds no bits to the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A chunk is offered this cycle |
| in_data | input | 16 | Coded bits, first bit at bit 15 |
| in_len | input | 5 | Number of real bits in `in_data` (0 to 16) |
| in_ready | output | 1 | Block can accept a chunk this cycle |
| out_valid | output | 1 | An output group is present |
| out_data | output | 8 | Output bits, first bit at bit 7, zero padded |
| out_len | output | 4 | Number of real bits in `out_data` (0 to 8) |

## Verification
Two things can happen in the same cycle: the held bits are drained, and a fresh chunk is merged behind them and split. If the held bits plus the new chunk exceed eight, a single cycle emits the oldest held bits, moves part of the new chunk to the output and stores the rest. Back-to-back sixteen-bit chunks, random lengths with random gaps, and garbage in the unused low input bits all provoke this. A scoreboard holds every accepted bit in order and judges each output cycle. It predicts `out_len` as min(8, pending bits), compares every emitted bit against the queue head, and checks `in_ready` against the count of held bits.

// File: rtl/bslb_pkg.sv
package bslb_pkg;

    // Kind of output group produced in a cycle
    typedef enum logic [1:0] {
        EMIT_NONE   = 2'd0,  // nothing merged this cycle
        EMIT_ALL    = 2'd1,  // every merged bit leaves now
        EMIT_CAPPED = 2'd2   // output capped, surplus retained
    } emit_e;

endpackage

// File: rtl/bslb_in_align.sv
module bslb_in_align #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8,
    parameter int LEN_W = 5,
    parameter int WIN_W = IN_W + OUT_W,
    parameter int CNT_W = $clog2(WIN_W + 1)
) (
    input  logic [IN_W-1:0]  in_data,
    input  logic [LEN_W-1:0] in_len,
    input  logic             take,
    input  logic [CNT_W-1:0] held_cnt,
    output logic [WIN_W-1:0] placed,
    output logic [CNT_W-1:0] eff_len
);

    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(IN_W);

    logic [LEN_W-1:0] clamp_len;
    logic [IN_W-1:0]  ones;
    logic [IN_W-1:0]  keep_mask;
    logic [IN_W-1:0]  clean;
    logic [WIN_W-1:0] wide;

    always_comb begin
        clamp_len = (in_len > LEN_CAP) ? LEN_CAP : in_len;
        ones      = '1;
        keep_mask = ~(ones >> clamp_len);
        clean     = in_data & keep_mask;
        wide      = {clean, {OUT_W{1'b0}}};
        placed    = take ? (wide >> held_cnt) : '0;
        eff_len   = take ? CNT_W'(clamp_len) : '0;
    end

endmodule

// File: rtl/bslb_split.sv
module bslb_split
    import bslb_pkg::*;
#(
    parameter int OUT_W  = 8,
    parameter int WIN_W  = 24,
    parameter int CNT_W  = 5,
    parameter int OLEN_W = 4
) (
    input  logic [WIN_W-1:0]  merged,
    input  logic [CNT_W-1:0]  total,
    output logic [OUT_W-1:0]  out_data,
    output logic [OLEN_W-1:0] out_len,
    output logic [WIN_W-1:0]  rem_bits,
    output logic [CNT_W-1:0]  rem_cnt,
    output emit_e             emit
);

    localparam logic [CNT_W-1:0] OUT_C = CNT_W'(OUT_W);

    logic             full;
    logic [CNT_W-1:0] take_cnt;

    always_comb begin
        full     = (total > OUT_C);
        take_cnt = full ? OUT_C : total;
        out_data = merged[WIN_W-1 -: OUT_W];
        out_len  = OLEN_W'(take_cnt);
        rem_bits = merged << take_cnt;
        rem_cnt  = total - take_cnt;
        if (total == '0) begin
            emit = EMIT_NONE;
        end else if (full) begin
            emit = EMIT_CAPPED;
        end else begin
            emit = EMIT_ALL;
        end
    end

endmodule

// File: rtl/bitstream_rate_limiter.sv
module bitstream_rate_limiter
    import bslb_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int OUT_W  = 8,
    parameter int LEN_W  = 5,
    parameter int OLEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    input  logic [LEN_W-1:0]  in_len,
    output logic              in_ready,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data,
    output logic [OLEN_W-1:0] out_len
);

    localparam int WIN_W = IN_W + OUT_W;
    localparam int CNT_W = $clog2(WIN_W + 1);
    localparam logic [CNT_W-1:0] READY_MAX = CNT_W'(WIN_W - IN_W);
    localparam logic [CNT_W-1:0] HOLD_MAX  = CNT_W'(WIN_W - OUT_W);

    typedef struct packed {
        logic [WIN_W-1:0] bits;
        logic [CNT_W-1:0] cnt;
    } hold_t;

    hold_t hold_d, hold_q;

    logic             take;
    logic [WIN_W-1:0] placed;
    logic [CNT_W-1:0] eff_len;
    logic [WIN_W-1:0] merged;
    logic [CNT_W-1:0] total;
    logic [WIN_W-1:0] rem_bits;
    logic [CNT_W-1:0] rem_cnt;
    emit_e            emit;

    assign in_ready = (hold_q.cnt <= READY_MAX);
    assign take     = in_valid & in_ready;

    bslb_in_align #(
        .IN_W (IN_W),
        .OUT_W(OUT_W),
        .LEN_W(LEN_W),
        .WIN_W(WIN_W),
        .CNT_W(CNT_W)
    ) i_align (
        .in_data (in_data),
        .in_len  (in_len),
        .take    (take),
        .held_cnt(hold_q.cnt),
        .placed  (placed),
        .eff_len (eff_len)
    );

    assign merged = hold_q.bits | placed;
    assign total  = hold_q.cnt + eff_len;

    bslb_split #(
        .OUT_W (OUT_W),
        .WIN_W (WIN_W),
        .CNT_W (CNT_W),
        .OLEN_W(OLEN_W)
    ) i_split (
        .merged  (merged),
        .total   (total),
        .out_data(out_data),
        .out_len (out_len),
        .rem_bits(rem_bits),
        .rem_cnt (rem_cnt),
        .emit    (emit)
    );

    assign out_valid = take | (hold_q.cnt != '0);

    always_comb begin
        hold_d      = hold_q;
        hold_d.bits = rem_bits;
        hold_d.cnt  = rem_cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q.cnt <= HOLD_MAX);  // R3

    AST_STALL_FULL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && out_len == OLEN_W'(OUT_W)));  // R5

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_len == '0 && hold_q.cnt == '0) |-> (out_valid && out_len == '0));  // R6

    AST_DRAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q.cnt != '0) |-> out_valid);  // R7

    AST_CAPPED_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (emit == EMIT_CAPPED) |=> out_valid);  // R3

    AST_SHORT_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len < OLEN_W'(OUT_W)) |=> (hold_q.cnt == '0));  // R2

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data << out_len) == '0));  // R9

endmodule

// File: tb/test_bitstream_rate_limiter.sv
module test_bitstream_rate_limiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic [4:0]  in_len = '0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic [3:0]  out_len;

    int  n_checks = 0;
    int  n_bad = 0;
    bit  acc_now = 1'b0;
    bit  running = 1'b0;
    bit  finished = 1'b0;
    bit  exp_q[$];

    always #10 clk = ~clk;  // 50 MHz

    bitstream_rate_limiter i_bitstream_rate_limiter (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_len   (in_len),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_len  (out_len)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Driver: offers a chunk until accepted; pushes only the real bits (R8)
    task automatic send(logic [15:0] d, int len);
        bit done = 1'b0;
        while (!done) begin
            @(posedge clk);
            #1;
            in_valid = 1'b1;
            in_data  = d;
            in_len   = 5'(len);
            chk(in_ready == (exp_q.size() <= 8), "R5", "in_ready", int'(in_ready),
                int'(exp_q.size() <= 8));
            if (in_ready) begin
                for (int i = 0; i < len; i++) exp_q.push_back(d[15-i]);
                acc_now = 1'b1;
                done    = 1'b1;
            end else begin
                acc_now = 1'b0;  // R10: refused chunk adds nothing
            end
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            in_data  = 16'($urandom);
            in_len   = 5'($urandom_range(16));
            acc_now  = 1'b0;
        end
    endtask

    // Monitor: compares each output cycle with the scoreboard queue
    always @(negedge clk) begin
        if (running && rst_n) begin
            int  pend;
            int  elen;
            bit  evalid;
            pend   = exp_q.size();
            evalid = acc_now || (pend > 0);
            chk(out_valid == evalid, acc_now ? "R2" : "R7", "out_valid",
                int'(out_valid), int'(evalid));
            if (evalid) begin
                elen = (pend > 8) ? 8 : pend;
                if (acc_now && pend == 0)
                    chk(out_len == 0, "R6", "out_len zero chunk", int'(out_len), 0);
                else if (pend > 8)
                    chk(int'(out_len) == elen, "R3", "out_len", int'(out_len), elen);
                else
                    chk(int'(out_len) == elen, "R2", "out_len", int'(out_len), elen);
                for (int i = 0; i < elen; i++) begin
                    // R4 order, R8 garbage never leaks into the stream
                    chk(out_data[7-i] == exp_q[0], "R4", "stream bit", int'(out_data[7-i]),
                        int'(exp_q[0]));
                    void'(exp_q.pop_front());
                end
                chk((out_data << elen) == 8'h00, "R9", "padding", int'(out_data), 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        running = 1'b1;

        // Byte-sized chunks with garbage below the length (R8)
        for (int k = 0; k < 20; k++) send(16'($urandom), 8);
        idle(3);

        // Back-to-back full chunks force stalls (R3, R5, R10)
        for (int k = 0; k < 12; k++) send(16'($urandom), 16);
        idle(4);

        // Single-bit chunks (R2)
        for (int k = 0; k < 20; k++) send(16'($urandom), 1);
        idle(3);

        // Zero-length chunk on an empty holding register (R6)
        send(16'hFFFF, 0);
        idle(2);
        send(16'hA5A5, 0);
        idle(2);

        // Residual drains with no input (R7)
        send(16'hFFFF, 16);
        send(16'h1234, 13);
        idle(6);

        // Mixed random lengths and gaps
        for (int k = 0; k < 400; k++) begin
            send(16'($urandom), $urandom_range(16));
            if ($urandom_range(3) == 0) idle($urandom_range(2) + 1);
        end
        idle(6);

        chk(exp_q.size() == 0, "R7", "bits left undelivered", exp_q.size(), 0);
        running  = 1'b0;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule